// File: doc/BRIEF.md
# Configurable Four-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It takes two operands and a two-bit operation select, and it drives one result of the same width as the operands. It has no clock, no storage, no status flags and no carry-out. The result follows the inputs directly.

The block does not fix the operation behind each select code. A catalogue of sixteen operations is built into the block. It covers arithmetic, shifts, bitwise logic and unsigned compares. Four elaboration-time parameters each hold a catalogue index, one for each select code. The same source can therefore be instantiated with many different operation sets, and each set is fixed when the design is built.

Catalogue indices: 0 add, 1 subtract, 2 multiply, 3 divide, 4 modulus, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 AND, 9 OR, 10 XOR, 11 NAND, 12 NOR, 13 equal, 14 less-than, 15 greater-than.

Top module: `cfg_alu`

## Requirements
- R1: Select code k (0 to 3 on `op_sel`) drives `result` with the catalogue operation whose index is held in parameter `OP_Ck`, using the indices listed above. The result follows the inputs with no clock.
- R2: Add and subtract treat the operands as unsigned. Subtract computes `op_a - op_b`. Both results wrap modulo 16.
- R3: Multiply returns the four least significant bits of the unsigned product `op_a * op_b`.
- R4: When `op_b` is non-zero, divide returns the unsigned quotient of `op_a` over `op_b` and modulus returns the remainder.
- R5: When `op_b` is zero, divide returns 4'hF and modulus returns `op_a` unchanged.
- R6: Shift left and logical shift right move `op_a` by the amount in `op_b` and fill with zeros. An amount of 4 or more gives 4'h0.
- R7: Arithmetic shift right moves `op_a` right by `op_b` and fills with bit 3 of `op_a`. An amount of 4 or more gives four copies of bit 3.
- R8: AND, OR, XOR, NAND and NOR combine `op_a` and `op_b` bit by bit, position by position.
- R9: Equal, less-than and greater-than compare `op_a` with `op_b` as unsigned values. Each returns 4'd1 when true and 4'd0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand; also the shift amount and the divisor |
| op_sel | input | 2 | Select code; the operation it picks is set by the parameters |
| result | output | 4 | Result of the selected operation |

## Verification
The assertions check algebraic relations on every evaluation:
- The quotient times the divisor plus the remainder rebuilds the dividend, and the remainder stays below a non-zero divisor.
- Subtract undoes add.
- The three compare outputs are mutually exclusive, and exactly one of them is true.
- NAND and NOR are the complements of AND and OR.
- The arithmetic shift agrees with the logical shift when the sign bit is clear.

Only the bench's scenarios can show the rest:
- That each select code reaches the operation its parameter names.
- That the divide-by-zero results are the values the requirements fix.
- That shift amounts of four or more saturate correctly.
- That the compares are unsigned rather than signed.

// File: rtl/cfg_alu_pkg.sv
package cfg_alu_pkg;

   localparam int unsigned N_OPS    = 16;
   localparam int unsigned N_CODES  = 4;
   localparam int unsigned SEL_W    = $clog2(N_CODES);
   localparam int unsigned IDX_W    = $clog2(N_OPS);

   typedef enum logic [IDX_W-1:0] {
      OPC_ADD  = 4'd0,
      OPC_SUB  = 4'd1,
      OPC_MUL  = 4'd2,
      OPC_DIV  = 4'd3,
      OPC_MOD  = 4'd4,
      OPC_SHL  = 4'd5,
      OPC_SHR  = 4'd6,
      OPC_SAR  = 4'd7,
      OPC_AND  = 4'd8,
      OPC_OR   = 4'd9,
      OPC_XOR  = 4'd10,
      OPC_NAND = 4'd11,
      OPC_NOR  = 4'd12,
      OPC_EQ   = 4'd13,
      OPC_LT   = 4'd14,
      OPC_GT   = 4'd15
   } alu_op_e;

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic [W-1:0] diff,
   output logic [W-1:0] prod,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam int unsigned WW = 2 * W;
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic b_zero;

   assign b_zero = (b == '0);

   always_comb begin
      sum  = a + b;
      diff = a - b;
      prod = a * b;
   end

   // divisor of zero: quotient saturates, remainder passes the dividend
   always_comb begin
      if (b_zero) begin
         quot = ALL_ONES;
         rem  = a;
      end else begin
         quot = a / b;
         rem  = a % b;
      end
   end

   always_comb begin
      p_addsub_inverse_r2: assert ((W'(sum - b) == a) && (W'(diff + b) == a))
         else $error("add/sub not mutually inverse");
      if (!b_zero) begin
         p_div_rebuild_r4: assert ((WW'(quot) * WW'(b) + WW'(rem)) == WW'(a))
            else $error("quotient and remainder do not rebuild dividend");
         p_rem_below_r4: assert (rem < b)
            else $error("remainder not below divisor");
      end
   end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] amt,
   output logic [W-1:0] shl,
   output logic [W-1:0] shr,
   output logic [W-1:0] sar
);
   logic          over;
   logic          sign;

   assign over = (32'(amt) >= W);
   assign sign = a[W-1];

   always_comb begin
      if (over) begin
         shl = '0;
         shr = '0;
         sar = {W{sign}};
      end else begin
         shl = a << amt;
         shr = a >> amt;
         sar = W'($signed(a) >>> amt);
      end
   end

   always_comb begin
      if (!sign) begin
         p_sar_matches_shr_r7: assert (sar == shr)
            else $error("arithmetic shift differs from logical for positive value");
      end
      if (over) begin
         p_shift_saturate_r6: assert ((shl == '0) && (shr == '0))
            else $error("large shift amount left bits behind");
      end
   end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] and_o,
   output logic [W-1:0] or_o,
   output logic [W-1:0] xor_o,
   output logic [W-1:0] nand_o,
   output logic [W-1:0] nor_o
);
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign and_o[i]  = a[i] & b[i];
         assign or_o[i]   = a[i] | b[i];
         assign xor_o[i]  = a[i] ^ b[i];
         assign nand_o[i] = ~(a[i] & b[i]);
         assign nor_o[i]  = ~(a[i] | b[i]);
      end
   endgenerate

   always_comb begin
      p_nand_nor_complement_r8: assert ((nand_o == ~and_o) && (nor_o == ~or_o))
         else $error("inverted gates are not complements");
      p_xor_partition_r8: assert ((xor_o | and_o) == or_o)
         else $error("xor and and do not cover or");
   end

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq,
   output logic         lt,
   output logic         gt
);
   assign eq = (a == b);
   assign lt = (a < b);
   assign gt = (a > b);

   always_comb begin
      p_cmp_exclusive_r9: assert ($countones({eq, lt, gt}) == 1)
         else $error("compare outcomes not exclusive");
   end

endmodule

// File: rtl/cfg_alu.sv
module cfg_alu
   import cfg_alu_pkg::*;
#(
   parameter int unsigned W    = 4,
   parameter int unsigned OP_C0 = 0,
   parameter int unsigned OP_C1 = 1,
   parameter int unsigned OP_C2 = 2,
   parameter int unsigned OP_C3 = 3
) (
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   input  logic [SEL_W-1:0] op_sel,
   output logic [W-1:0]     result
);
   localparam logic [W-1:0] ZERO_HI = '0;

   // elaboration-time parameter checks
   generate
      if (W < 2) begin : g_bad_width
         $error("cfg_alu: W must be at least 2");
      end
      if (OP_C0 >= N_OPS || OP_C1 >= N_OPS || OP_C2 >= N_OPS || OP_C3 >= N_OPS) begin : g_bad_idx
         $error("cfg_alu: operation index outside catalogue");
      end
   endgenerate

   logic [W-1:0] r_sum, r_diff, r_prod, r_quot, r_rem;
   logic [W-1:0] r_shl, r_shr, r_sar;
   logic [W-1:0] r_and, r_or, r_xor, r_nand, r_nor;
   logic         c_eq, c_lt, c_gt;

   alu_arith_unit #(.W(W)) u_arith (
      .a(op_a), .b(op_b),
      .sum(r_sum), .diff(r_diff), .prod(r_prod), .quot(r_quot), .rem(r_rem)
   );

   alu_shift_unit #(.W(W)) u_shift (
      .a(op_a), .amt(op_b),
      .shl(r_shl), .shr(r_shr), .sar(r_sar)
   );

   alu_logic_unit #(.W(W)) u_logic (
      .a(op_a), .b(op_b),
      .and_o(r_and), .or_o(r_or), .xor_o(r_xor), .nand_o(r_nand), .nor_o(r_nor)
   );

   alu_cmp_unit #(.W(W)) u_cmp (
      .a(op_a), .b(op_b),
      .eq(c_eq), .lt(c_lt), .gt(c_gt)
   );

   // catalogue of all results, indexed by operation code
   logic [W-1:0] cat [N_OPS];

   always_comb begin
      cat[OPC_ADD]  = r_sum;
      cat[OPC_SUB]  = r_diff;
      cat[OPC_MUL]  = r_prod;
      cat[OPC_DIV]  = r_quot;
      cat[OPC_MOD]  = r_rem;
      cat[OPC_SHL]  = r_shl;
      cat[OPC_SHR]  = r_shr;
      cat[OPC_SAR]  = r_sar;
      cat[OPC_AND]  = r_and;
      cat[OPC_OR]   = r_or;
      cat[OPC_XOR]  = r_xor;
      cat[OPC_NAND] = r_nand;
      cat[OPC_NOR]  = r_nor;
      cat[OPC_EQ]   = {ZERO_HI[W-1:1], c_eq};
      cat[OPC_LT]   = {ZERO_HI[W-1:1], c_lt};
      cat[OPC_GT]   = {ZERO_HI[W-1:1], c_gt};
   end

   // per select code, bind the parameter-chosen catalogue entry
   logic [W-1:0] by_code [N_CODES];

   genvar k;
   generate
      for (k = 0; k < N_CODES; k++) begin : g_code
         localparam int unsigned IDX = (k == 0) ? OP_C0 :
                                       (k == 1) ? OP_C1 :
                                       (k == 2) ? OP_C2 : OP_C3;
         assign by_code[k] = cat[IDX[IDX_W-1:0]];
      end
   endgenerate

   assign result = by_code[op_sel];

endmodule

// File: tb/sim_cfg_alu.sv
module sim_cfg_alu;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a = '0, b = '0;
   logic [1:0] sel = '0;
   logic [3:0] y0, y1, y2, y3;
   int         n_checks = 0;
   int         n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // four instances together cover all sixteen catalogue entries (R1)
   cfg_alu #(.OP_C0(0),  .OP_C1(1),  .OP_C2(2),  .OP_C3(3))  u0 (.op_a(a), .op_b(b), .op_sel(sel), .result(y0));
   cfg_alu #(.OP_C0(4),  .OP_C1(5),  .OP_C2(6),  .OP_C3(7))  u1 (.op_a(a), .op_b(b), .op_sel(sel), .result(y1));
   cfg_alu #(.OP_C0(11), .OP_C1(10), .OP_C2(9),  .OP_C3(8))  u2 (.op_a(a), .op_b(b), .op_sel(sel), .result(y2));
   cfg_alu #(.OP_C0(15), .OP_C1(12), .OP_C2(14), .OP_C3(13)) u3 (.op_a(a), .op_b(b), .op_sel(sel), .result(y3));

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: a=%h b=%h sel=%0d got=%h expected=%h", tag, a, b, sel, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] ta, input logic [3:0] tb, input logic [1:0] ts);
      @(negedge clk);
      a = ta; b = tb; sel = ts;
      #1;
   endtask

   // reference model written from the requirement list
   function automatic logic [3:0] model(input int op, input logic [3:0] x, input logic [3:0] z);
      logic [7:0] p;
      case (op)
         0:  return x + z;
         1:  return x - z;
         2:  begin p = {4'h0, x} * {4'h0, z}; return p[3:0]; end
         3:  return (z == 0) ? 4'hF : x / z;
         4:  return (z == 0) ? x : x % z;
         5:  return (z >= 4) ? 4'h0 : x << z;
         6:  return (z >= 4) ? 4'h0 : x >> z;
         7:  return (z >= 4) ? {4{x[3]}} : 4'($signed(x) >>> z);
         8:  return x & z;
         9:  return x | z;
         10: return x ^ z;
         11: return ~(x & z);
         12: return ~(x | z);
         13: return (x == z) ? 4'd1 : 4'd0;
         14: return (x < z) ? 4'd1 : 4'd0;
         default: return (x > z) ? 4'd1 : 4'd0;
      endcase
   endfunction

   task automatic t_idle_state;
      apply(4'h0, 4'h0, 2'd0);
      check("R1 idle add", y0, 4'h0);
      check("R5 idle mod by zero", y1, 4'h0);
      check("R8 idle nand", y2, 4'hF);
      check("R9 idle gt", y3, 4'h0);
   endtask

   task automatic t_map_r1;
      apply(4'h6, 4'h3, 2'd0); check("R1 code0->add", y0, 4'h9);
      apply(4'h6, 4'h3, 2'd1); check("R1 code1->sub", y0, 4'h3);
      apply(4'h6, 4'h3, 2'd2); check("R1 code2->mul", y0, 4'h2);
      apply(4'h6, 4'h3, 2'd3); check("R1 code3->div", y0, 4'h2);
      apply(4'h6, 4'h3, 2'd3); check("R1 u2 code3->and", y2, 4'h2);
      apply(4'h6, 4'h3, 2'd0); check("R1 u2 code0->nand", y2, 4'hD);
      // input change with no clock edge reaches the output
      #1 a = 4'h1; #1;
      check("R1 combinational follow", y0, 4'h4);
   endtask

   task automatic t_arith_r2_r3;
      apply(4'h9, 4'h8, 2'd0); check("R2 add wrap", y0, 4'h1);
      apply(4'h3, 4'h5, 2'd1); check("R2 sub wrap", y0, 4'hE);
      apply(4'h7, 4'h5, 2'd2); check("R3 mul low bits", y0, 4'h3);
      apply(4'hF, 4'hF, 2'd2); check("R3 mul max", y0, 4'h1);
   endtask

   task automatic t_div_r4_r5;
      apply(4'hD, 4'h4, 2'd3); check("R4 quotient", y0, 4'h3);
      apply(4'hD, 4'h4, 2'd0); check("R4 remainder", y1, 4'h1);
      apply(4'hD, 4'h0, 2'd3); check("R5 div by zero", y0, 4'hF);
      apply(4'hD, 4'h0, 2'd0); check("R5 mod by zero", y1, 4'hD);
   endtask

   task automatic t_shift_r6_r7;
      apply(4'h3, 4'h2, 2'd1); check("R6 shl", y1, 4'hC);
      apply(4'h3, 4'h5, 2'd1); check("R6 shl saturate", y1, 4'h0);
      apply(4'hC, 4'h2, 2'd2); check("R6 shr", y1, 4'h3);
      apply(4'hC, 4'h4, 2'd2); check("R6 shr saturate", y1, 4'h0);
      apply(4'hA, 4'h1, 2'd3); check("R7 sar negative", y1, 4'hD);
      apply(4'hA, 4'h7, 2'd3); check("R7 sar saturate", y1, 4'hF);
      apply(4'h6, 4'h1, 2'd3); check("R7 sar positive", y1, 4'h3);
      apply(4'h6, 4'hF, 2'd3); check("R7 sar positive saturate", y1, 4'h0);
   endtask

   task automatic t_logic_r8;
      apply(4'hC, 4'hA, 2'd3); check("R8 and", y2, 4'h8);
      apply(4'hC, 4'hA, 2'd2); check("R8 or", y2, 4'hE);
      apply(4'hC, 4'hA, 2'd1); check("R8 xor", y2, 4'h6);
      apply(4'hC, 4'hA, 2'd0); check("R8 nand", y2, 4'h7);
      apply(4'hC, 4'hA, 2'd1); check("R8 nor", y3, 4'h1);
   endtask

   task automatic t_cmp_r9;
      apply(4'h5, 4'h5, 2'd3); check("R9 eq true", y3, 4'h1);
      apply(4'h3, 4'h9, 2'd2); check("R9 lt true", y3, 4'h1);
      apply(4'h3, 4'h9, 2'd0); check("R9 gt false", y3, 4'h0);
      apply(4'h9, 4'h3, 2'd2); check("R9 lt unsigned", y3, 4'h0);
      apply(4'h9, 4'h3, 2'd0); check("R9 gt unsigned", y3, 4'h1);
   endtask

   task automatic t_sweep;
      for (int s = 0; s < 4; s++) begin
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               apply(4'(i), 4'(j), 2'(s));
               check("R1 sweep u0", y0, model(s, 4'(i), 4'(j)));
               check("R1 sweep u1", y1, model(4 + s, 4'(i), 4'(j)));
               check("R1 sweep u2", y2, model(11 - s, 4'(i), 4'(j)));
               check("R1 sweep u3", y3, model((s == 0) ? 15 : (s == 1) ? 12 : (s == 2) ? 14 : 13, 4'(i), 4'(j)));
            end
         end
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle_state;
      t_map_r1;
      t_arith_r2_r3;
      t_div_r4_r5;
      t_shift_r6_r7;
      t_logic_r8;
      t_cmp_r9;
      t_sweep;
      summary;
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got=timeout expected=completion");
      summary;
      $finish;
   end

endmodule